// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on a 4-bit receive interface that delivers one nibble per clock while a data-valid line is high. It hunts for the frame start (one or more preamble nibbles of 0x5 followed by the delimiter nibble 0xD) and collects the twelve nibbles of the destination address. It sorts the address into a class: own station, broadcast, multicast or other unicast.

An external lookup engine reports a match on a single input. The block samples that input over a fixed span of clocks that starts with the first address nibble. When the span closes, the block combines the address class, the sampled match and the operating mode, which is normal or promiscuous-lookup. From these it produces a single-cycle verdict: accept or discard, the class code and a filter-hit flag. A match reverses the normal-mode verdict. In promiscuous-lookup mode a match discards everything, and the absence of a match accepts everything.

The mode and the station address are captured when the frame-start delimiter is seen. A frame that ends before its address is complete produces no verdict.

Top module: `maf_rx_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept`, `dec_filter_hit` are low and `dec_class` is 0, and no verdict is ever produced for a frame whose start was not recognised.
- R2: A frame start is recognised only when nibble 0xD follows at least one 0x5 nibble with `rx_dv` held high. If the first valid nibble is 0xD, or another value interrupts the preamble, the frame is ignored until `rx_dv` falls.
- R3: The twelve nibbles after the delimiter form the address. Within each octet the low nibble comes first, and the first octet on the wire is the first octet. Class codes: 1 = exact match with `station_addr`; otherwise 2 = all 48 bits one; otherwise 3 = bit 0 of the first octet set; otherwise 0.
- R4: In normal mode (`promisc_cam` = 0), when the match was seen, classes 1, 2 and 3 are discarded and class 0 is accepted.
- R5: In normal mode, when the match was not seen, classes 1, 2 and 3 are accepted and class 0 is discarded.
- R6: In promiscuous-lookup mode (`promisc_cam` = 1), when the match was seen, every frame is discarded.
- R7: In promiscuous-lookup mode, when the match was not seen, every frame is accepted.
- R8: `cam_match` counts as seen if it is high on any of the WIN_CYCLES (default 35) clocks that start with the clock sampling the first address nibble. A high level outside that span, including on the delimiter clock, has no effect. `dec_filter_hit` reports whether the match was seen.
- R9: The verdict appears as a single-cycle `dec_valid` pulse one clock after the last clock of the match span. With the delimiter sampled on edge N, the pulse is visible between edges N+35 and N+36.
- R10: If `rx_dv` falls before all twelve address nibbles have arrived, the frame produces no verdict.
- R11: Changes to `promisc_cam` or `station_addr` during a frame do not affect that frame's verdict. The values sampled on the delimiter clock are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_dv | input | 1 | Receive data valid |
| rxd | input | 4 | Receive nibble |
| cam_match | input | 1 | External address lookup match |
| promisc_cam | input | 1 | 1 = promiscuous-lookup mode, 0 = normal mode |
| station_addr | input | 48 | Own station address, first wire octet in bits 47:40 |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | 1 = accept, 0 = discard (valid with strobe) |
| dec_class | output | 2 | Address class code (valid with strobe) |
| dec_filter_hit | output | 1 | Match was seen within the span (valid with strobe) |

## Verification
Every cycle, the assertions check these properties:
- the verdict strobe lasts exactly one cycle and comes only right after the last cycle of a span;
- a recognised delimiter always follows a preamble nibble;
- the latched hit stays set until the span ends;
- an early drop of `rx_dv` closes the span without a verdict;
- the accept bit agrees with the mode, the class and the hit flag.

Only the bench's scenarios can show the rest. That covers the octet and nibble assembly order, the class priority and the exact edges of the sampling span (its last clock counts, the delimiter clock and the clock after the span do not). It also covers rejection of a malformed preamble and the freezing of mode and station address at the delimiter.

// File: rtl/maf_pkg.sv
package maf_pkg;

  localparam int MAF_NIB_W   = 4;
  localparam int MAF_ADDR_W  = 48;
  localparam int MAF_NIBS    = MAF_ADDR_W / MAF_NIB_W;
  localparam logic [MAF_NIB_W-1:0] MAF_NIB_PRE = 4'h5;
  localparam logic [MAF_NIB_W-1:0] MAF_NIB_SFD = 4'hD;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_OWN   = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_MCAST = 2'd3
  } maf_class_e;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_PRE   = 2'd1,
    FS_WIN   = 2'd2,
    FS_DRAIN = 2'd3
  } maf_fstate_e;

endpackage

// File: rtl/maf_frame_ctrl.sv
module maf_frame_ctrl
  import maf_pkg::*;
#(
  parameter int WIN_CYCLES = 35,
  parameter int CNT_W      = $clog2(WIN_CYCLES),
  parameter int IDX_W      = $clog2(MAF_NIBS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_dv,
  input  logic [MAF_NIB_W-1:0] rxd,
  output logic                 sfd_pulse,
  output logic                 in_win,
  output logic                 win_last,
  output logic                 addr_open,
  output logic                 nib_we,
  output logic [IDX_W-1:0]     nib_idx
);

  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_NIBS  = CNT_W'(MAF_NIBS);

  if (WIN_CYCLES < MAF_NIBS) begin : g_bad_win
    $error("WIN_CYCLES must cover the whole destination address");
  end

  maf_fstate_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             abort;

  assign in_win    = (state_q == FS_WIN);
  assign addr_open = in_win && (cnt_q < CNT_NIBS);
  assign abort     = addr_open && !rx_dv;
  assign win_last  = in_win && !abort && (cnt_q == CNT_LAST);
  assign nib_we    = addr_open && rx_dv;
  assign nib_idx   = cnt_q[IDX_W-1:0];

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sfd_pulse = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (rx_dv) begin
          state_d = (rxd == MAF_NIB_PRE) ? FS_PRE : FS_DRAIN;
        end
      end
      FS_PRE: begin
        if (!rx_dv) begin
          state_d = FS_IDLE;
        end else if (rxd == MAF_NIB_SFD) begin
          state_d   = FS_WIN;
          cnt_d     = '0;
          sfd_pulse = 1'b1;
        end else if (rxd != MAF_NIB_PRE) begin
          state_d = FS_DRAIN;
        end
      end
      FS_WIN: begin
        if (abort) begin
          state_d = FS_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == CNT_LAST) begin
          state_d = rx_dv ? FS_DRAIN : FS_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      FS_DRAIN: begin
        if (!rx_dv) begin
          state_d = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/maf_addr_capture.sv
module maf_addr_capture
  import maf_pkg::*;
#(
  parameter int IDX_W = $clog2(MAF_NIBS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nib_we,
  input  logic [IDX_W-1:0]      nib_idx,
  input  logic [MAF_NIB_W-1:0]  rxd,
  output logic [MAF_ADDR_W-1:0] addr
);

  for (genvar n = 0; n < MAF_NIBS; n++) begin : g_nib
    localparam int OCTET = n / 2;
    localparam int LSB   = MAF_ADDR_W - 8 - 8 * OCTET + MAF_NIB_W * (n % 2);

    logic                 slot_en;
    logic [MAF_NIB_W-1:0] slot_q;

    assign slot_en = nib_we && (nib_idx == IDX_W'(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= rxd;
      end
    end

    assign addr[LSB +: MAF_NIB_W] = slot_q;
  end

endmodule

// File: rtl/maf_classify.sv
module maf_classify
  import maf_pkg::*;
(
  input  logic [MAF_ADDR_W-1:0] addr,
  input  logic [MAF_ADDR_W-1:0] station,
  output maf_class_e            cls
);

  logic is_own;
  logic is_bcast;
  logic is_group;

  assign is_own   = (addr == station);
  assign is_bcast = &addr;
  assign is_group = addr[MAF_ADDR_W-8];

  always_comb begin
    if (is_own) begin
      cls = CLS_OWN;
    end else if (is_bcast) begin
      cls = CLS_BCAST;
    end else if (is_group) begin
      cls = CLS_MCAST;
    end else begin
      cls = CLS_OTHER;
    end
  end

endmodule

// File: rtl/maf_cam_window.sv
module maf_cam_window (
  input  logic clk,
  input  logic rst_n,
  input  logic sfd_pulse,
  input  logic in_win,
  input  logic cam_match,
  output logic hit_q,
  output logic hit_seen
);

  logic hit_d;
  logic hit_en;

  assign hit_seen = hit_q || (in_win && cam_match);
  assign hit_en   = sfd_pulse || in_win;
  assign hit_d    = sfd_pulse ? 1'b0 : hit_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else if (hit_en) begin
      hit_q <= hit_d;
    end
  end

endmodule

// File: rtl/maf_rx_filter.sv
module maf_rx_filter
  import maf_pkg::*;
#(
  parameter int WIN_CYCLES = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_dv,
  input  logic [3:0]  rxd,
  input  logic        cam_match,
  input  logic        promisc_cam,
  input  logic [47:0] station_addr,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic [1:0]  dec_class,
  output logic        dec_filter_hit
);

  localparam int CNT_W = $clog2(WIN_CYCLES);
  localparam int IDX_W = $clog2(MAF_NIBS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic                  sfd_pulse;
  logic                  in_win;
  logic                  win_last;
  logic                  addr_open;
  logic                  nib_we;
  logic [IDX_W-1:0]      nib_idx;
  logic [MAF_ADDR_W-1:0] addr_q;
  logic                  hit_q;
  logic                  hit_seen;
  maf_class_e            cls_now;

  maf_frame_ctrl #(
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rx_dv     (rx_dv),
    .rxd       (rxd),
    .sfd_pulse (sfd_pulse),
    .in_win    (in_win),
    .win_last  (win_last),
    .addr_open (addr_open),
    .nib_we    (nib_we),
    .nib_idx   (nib_idx)
  );

  maf_addr_capture #(
    .IDX_W (IDX_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .nib_we  (nib_we),
    .nib_idx (nib_idx),
    .rxd     (rxd),
    .addr    (addr_q)
  );

  maf_cam_window u_cam (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sfd_pulse (sfd_pulse),
    .in_win    (in_win),
    .cam_match (cam_match),
    .hit_q     (hit_q),
    .hit_seen  (hit_seen)
  );

  // per-frame copies of the configuration, frozen at the delimiter
  logic                  mode_q;
  logic [MAF_ADDR_W-1:0] stn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      stn_q  <= '0;
    end else if (sfd_pulse) begin
      mode_q <= promisc_cam;
      stn_q  <= station_addr;
    end
  end

  maf_classify u_cls (
    .addr    (addr_q),
    .station (stn_q),
    .cls     (cls_now)
  );

  // verdict
  logic       accept_d;
  logic       valid_q;
  logic       accept_q;
  logic       fhit_q;
  maf_class_e class_q;

  always_comb begin
    if (mode_q) begin
      accept_d = !hit_seen;
    end else if (hit_seen) begin
      accept_d = (cls_now == CLS_OTHER);
    end else begin
      accept_d = (cls_now != CLS_OTHER);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= win_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      fhit_q   <= 1'b0;
      class_q  <= CLS_OTHER;
    end else if (win_last) begin
      accept_q <= accept_d;
      fhit_q   <= hit_seen;
      class_q  <= cls_now;
    end
  end

  assign dec_valid      = valid_q;
  assign dec_accept     = accept_q;
  assign dec_class      = class_q;
  assign dec_filter_hit = fhit_q;

endmodule

// File: rtl/maf_checker.sv
module maf_checker
  import maf_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       rx_dv,
  input logic [3:0] rxd,
  input logic       sfd_pulse,
  input logic       in_win,
  input logic       win_last,
  input logic       addr_open,
  input logic       hit_q,
  input logic       mode_q,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [1:0] dec_class,
  input logic       dec_filter_hit
);

  AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_valid |=> !dec_valid);  // R9

  AST_DEC_AFTER_SPAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec_valid |-> $past(win_last));  // R9

  AST_SFD_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sfd_pulse |-> ($past(rx_dv) && ($past(rxd) == 4'h5)));  // R2

  AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit_q && in_win && !win_last) |=> hit_q);  // R8

  AST_EARLY_DROP_ABORTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_open && !rx_dv) |=> (!in_win && !dec_valid));  // R10

  AST_PROMISC_HIT_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && mode_q && dec_filter_hit) |-> !dec_accept);  // R6

  AST_PROMISC_CLEAN_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && mode_q && !dec_filter_hit) |-> dec_accept);  // R7

  AST_NORMAL_HIT_INVERTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && !mode_q && dec_filter_hit) |-> (dec_accept == (dec_class == 2'd0)));  // R4

  AST_NORMAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dec_valid && !mode_q && !dec_filter_hit) |-> (dec_accept == (dec_class != 2'd0)));  // R5

endmodule

bind maf_rx_filter maf_checker u_maf_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .rx_dv          (rx_dv),
  .rxd            (rxd),
  .sfd_pulse      (sfd_pulse),
  .in_win         (in_win),
  .win_last       (win_last),
  .addr_open      (addr_open),
  .hit_q          (hit_q),
  .mode_q         (mode_q),
  .dec_valid      (dec_valid),
  .dec_accept     (dec_accept),
  .dec_class      (dec_class),
  .dec_filter_hit (dec_filter_hit)
);

// File: tb/sim_maf_rx_filter.sv
`timescale 1ns/1ps
module sim_maf_rx_filter;

  logic        clk;
  logic        rst_n;
  logic        rx_dv;
  logic [3:0]  rxd;
  logic        cam_match;
  logic        promisc_cam;
  logic [47:0] station_addr;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_class;
  logic        dec_filter_hit;

  int checks = 0;
  int errors = 0;

  localparam logic [47:0] STN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h10_00_00_00_00_01;

  maf_rx_filter u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_dv          (rx_dv),
    .rxd            (rxd),
    .cam_match      (cam_match),
    .promisc_cam    (promisc_cam),
    .station_addr   (station_addr),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept),
    .dec_class      (dec_class),
    .dec_filter_hit (dec_filter_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [47:0]       da;
    logic              mode;
    logic signed [7:0] cam;   // relative drive slot, -1 = never
    logic [1:0]        cls;
    logic              acc;
    logic              hit;
    logic [3:0]        req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{48'h02_11_22_33_44_55, 1'b0, -8'sd1,  2'd1, 1'b1, 1'b0, 4'd5},  // R5 own
    '{48'hFF_FF_FF_FF_FF_FF, 1'b0,  8'sd5,  2'd2, 1'b0, 1'b1, 4'd4},  // R4 broadcast
    '{48'h01_00_5E_00_00_01, 1'b0, -8'sd1,  2'd3, 1'b1, 1'b0, 4'd5},  // R5 multicast
    '{48'h00_AA_BB_CC_DD_EE, 1'b0, -8'sd1,  2'd0, 1'b0, 1'b0, 4'd5},  // R5 other
    '{48'h00_AA_BB_CC_DD_EE, 1'b0,  8'sd20, 2'd0, 1'b1, 1'b1, 4'd4},  // R4 other hit
    '{48'h02_11_22_33_44_55, 1'b0,  8'sd1,  2'd1, 1'b0, 1'b1, 4'd4},  // R4 own hit
    '{48'h01_00_5E_00_00_01, 1'b1,  8'sd10, 2'd3, 1'b0, 1'b1, 4'd6},  // R6
    '{48'h00_AA_BB_CC_DD_EE, 1'b1, -8'sd1,  2'd0, 1'b1, 1'b0, 4'd7},  // R7 other
    '{48'hFF_FF_FF_FF_FF_FF, 1'b1, -8'sd1,  2'd2, 1'b1, 1'b0, 4'd7},  // R7 broadcast
    '{48'h00_AA_BB_CC_DD_EE, 1'b0,  8'sd35, 2'd0, 1'b1, 1'b1, 4'd8},  // R8 last slot
    '{48'h00_AA_BB_CC_DD_EE, 1'b0,  8'sd36, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 too late
    '{48'h02_11_22_33_44_55, 1'b0,  8'sd0,  2'd1, 1'b1, 1'b0, 4'd8},  // R8 delimiter slot
    '{48'h10_00_00_00_00_00, 1'b0, -8'sd1,  2'd0, 1'b0, 1'b0, 4'd3},  // R3 nibble order
    '{48'hFF_FF_FF_FF_FF_FE, 1'b0, -8'sd1,  2'd3, 1'b1, 1'b0, 4'd3}   // R3 not broadcast
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one frame: rel 0 carries the delimiter, rel 1..12 the address.
  task automatic run_frame(input string req, input logic [47:0] da,
                           input logic mode, input logic [47:0] stn,
                           input int pre_n, input logic bad_pre,
                           input int da_nibs, input int cam_off,
                           input logic expect_dec, input logic [1:0] ecls,
                           input logic eacc, input logic ehit,
                           input logic chg, input logic mode2,
                           input logic [47:0] stn2);
    int         pulses = 0;
    int         prel = 0;
    logic [1:0] gcls = 2'd0;
    logic       gacc = 1'b0;
    logic       ghit = 1'b0;
    for (int rel = -pre_n - 1; rel <= 45; rel++) begin
      @(negedge clk);
      if (dec_valid) begin
        pulses++;
        prel = rel;
        gcls = dec_class;
        gacc = dec_accept;
        ghit = dec_filter_hit;
      end
      cam_match = (cam_off >= 0) && (rel == cam_off);
      if (rel == -pre_n - 1) begin
        rx_dv        = 1'b0;
        rxd          = 4'h0;
        promisc_cam  = mode;
        station_addr = stn;
      end else if (rel < 0) begin
        rx_dv = 1'b1;
        rxd   = (bad_pre && rel == -1) ? 4'hA : 4'h5;
      end else if (rel == 0) begin
        rx_dv = 1'b1;
        rxd   = 4'hD;
      end else if (rel <= da_nibs) begin
        logic [7:0] oct;
        oct   = da[47 - 8 * ((rel - 1) / 2) -: 8];
        rx_dv = 1'b1;
        rxd   = ((rel - 1) % 2 == 0) ? oct[3:0] : oct[7:4];
      end else if (da_nibs == 12 && rel <= 18) begin
        rx_dv = 1'b1;
        rxd   = 4'h3;
      end else begin
        rx_dv = 1'b0;
        rxd   = 4'h0;
      end
      if (chg && rel == 3) begin
        promisc_cam  = mode2;
        station_addr = stn2;
      end
    end
    cam_match = 1'b0;
    rx_dv     = 1'b0;
    if (expect_dec) begin
      check(req, "pulse count", 64'(pulses), 64'd1);
      check(req, "pulse slot", 64'(prel), 64'd36);
      check(req, "class", 64'(gcls), 64'(ecls));
      check(req, "accept", 64'(gacc), 64'(eacc));
      check(req, "filter hit", 64'(ghit), 64'(ehit));
    end else begin
      check(req, "no verdict", 64'(pulses), 64'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    rx_dv        = 1'b0;
    rxd          = 4'h0;
    cam_match    = 1'b0;
    promisc_cam  = 1'b0;
    station_addr = STN;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "dec_valid in reset", 64'(dec_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "dec_valid idle", 64'(dec_valid), 64'd0);
    check("R1", "dec_accept idle", 64'(dec_accept), 64'd0);
    check("R1", "dec_class idle", 64'(dec_class), 64'd0);
    check("R1", "dec_filter_hit idle", 64'(dec_filter_hit), 64'd0);

    // table of address, mode and lookup-timing cases
    for (int i = 0; i < NVEC; i++) begin
      run_frame($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].da,
                VECS[i].mode, STN, 3, 1'b0, 12, int'(VECS[i].cam), 1'b1,
                VECS[i].cls, VECS[i].acc, VECS[i].hit, 1'b0, 1'b0, STN);
    end

    // R2: delimiter with no preamble, and a corrupted preamble
    run_frame("R2 no preamble", STN, 1'b0, STN, 0, 1'b0, 12, -1,
              1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, STN);
    run_frame("R2 bad preamble", STN, 1'b0, STN, 4, 1'b1, 12, -1,
              1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, STN);
    // R2: a single preamble nibble is enough
    run_frame("R2 short preamble", STN, 1'b0, STN, 1, 1'b0, 12, -1,
              1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, STN);

    // R10: data-valid drops after seven address nibbles, lookup hit ignored too
    run_frame("R10 early drop", STN, 1'b0, STN, 3, 1'b0, 7, 4,
              1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, STN);
    run_frame("R10 recovery", OTHER, 1'b0, STN, 3, 1'b0, 12, -1,
              1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, STN);

    // R11: configuration changed mid-frame is not used for this frame
    run_frame("R11 station change", STN, 1'b0, STN, 3, 1'b0, 12, -1,
              1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, OTHER);
    run_frame("R11 mode change", OTHER, 1'b0, STN, 3, 1'b0, 12, -1,
              1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, STN);

    repeat (4) @(negedge clk);
    check("R9", "no stray verdict", 64'(dec_valid), 64'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule